// File: doc/BRIEF.md
# Maskable Output Macrocell Bank

The block holds a bank of output macrocell flip-flops, organised as groups of eight. Each cell normally takes a next-state value from surrounding logic whenever its load strobe is high. A microcontroller can also overwrite a whole group of cells at once through a small register write port. Each group has an 8-bit write-protect register. A set protect bit shields the matching cell from microcontroller writes, so cells that hold state-machine state stay intact. Unprotected cells in the same write still take the new data.

Every cell's value is always available on a feedback output so that it can reach the logic array as an internal node. A build-time map marks which cells drive a pin. Among the pin cells, a second map marks those that have an enable equation. A pin cell with an equation is enabled by its product-term input ORed with its direction-register bit. A pin cell without an equation is enabled from reset onward. A cell that is only an internal node never enables a pin.

All registers are written and read back through one address space. The address is split into a register kind (upper two bits) and a group index (lower bits).

Top module: `omc_bank`

## Requirements
- R1: After reset every macrocell, protect and direction register reads back 00h and every cell output is 0.
- R2: A CPU write to kind 00 (macrocell) of group g loads the write data into the unprotected cells of group g at the next clock edge.
- R3: A cell whose protect bit is 1 keeps its value through a CPU macrocell write.
- R4: With a group's protect register at 0Fh, a CPU macrocell write changes only cells 4 to 7 of that group, and cells 0 to 3 keep their values.
- R5: When a CPU macrocell write and a logic load hit the same cell in the same cycle, an unprotected cell takes the CPU data and a protected cell takes the logic next-state value.
- R6: With load high and no effective CPU write, a cell takes its next-state input at the next edge. With load low and no CPU write, the cell holds its value.
- R7: A write to one group's registers leaves every register of the other groups unchanged.
- R8: For a pin cell with an enable equation, the pin enable equals its product-term input ORed with its direction bit. Direction is kind 10, one bit per cell of the group.
- R9: A pin cell with no enable equation has its enable at 1 from reset. An internal-node cell's enable is always 0. With the default maps, cell 0 has no equation and cell 15 is internal only.
- R10: The feedback output of every cell equals that cell's register output, including for internal-node cells.
- R11: The protect register is kind 01 and reads back as written. Kind 11 is reserved: it reads 00h and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_we_i | input | 1 | CPU register write strobe |
| cpu_addr_i | input | 3 | Register address: {kind[1:0], group} |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Read-back data for cpu_addr_i (combinational) |
| mc_load_i | input | 16 | Per-cell logic load strobe |
| mc_next_i | input | 16 | Per-cell next-state value from logic |
| pt_oe_i | input | 16 | Per-pin output-enable product term |
| mc_q_o | output | 16 | Macrocell register outputs |
| mc_fb_o | output | 16 | Feedback to the logic array |
| pin_oe_o | output | 16 | Per-pin driver enable |

## Verification
The assertions assume that the reset is released synchronously with respect to the checks that follow it. They also assume that the address and write data stay stable for the whole cycle in which the write strobe is high. The bench meets both by driving every input on the falling clock edge and holding it across the next rising edge. The assertions assume nothing about how load strobes and CPU writes are combined. The bench deliberately raises both in the same cycle on a group that is partly protected.

// File: rtl/omc_pkg.sv
package omc_pkg;
  typedef enum logic [1:0] {
    KIND_CELL = 2'b00,
    KIND_MASK = 2'b01,
    KIND_DIR  = 2'b10,
    KIND_RSVD = 2'b11
  } reg_kind_e;
endpackage

// File: rtl/omc_ctrl_regs.sv
module omc_ctrl_regs
  import omc_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int WIDTH  = 8,
  parameter int GRP_W  = 1,
  localparam int N     = GROUPS * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  reg_kind_e        kind_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [N-1:0]     mask_o,
  output logic [N-1:0]     dir_o,
  output logic [GROUPS-1:0] cell_we_o
);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic sel;
    assign sel = we_i && (grp_i == GRP_W'(g));
    assign cell_we_o[g] = sel && (kind_i == KIND_CELL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[g*WIDTH +: WIDTH] <= '0;
        dir_o[g*WIDTH +: WIDTH]  <= '0;
      end else if (sel) begin
        if (kind_i == KIND_MASK) mask_o[g*WIDTH +: WIDTH] <= wdata_i;
        if (kind_i == KIND_DIR)  dir_o[g*WIDTH +: WIDTH]  <= wdata_i;
      end
    end

    AST_OTHER_GRP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && grp_i != GRP_W'(g)) |=> ($stable(mask_o[g*WIDTH +: WIDTH]) && $stable(dir_o[g*WIDTH +: WIDTH]))); // R7
  end

  AST_RSVD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kind_i == KIND_RSVD) |=> ($stable(mask_o) && $stable(dir_o))); // R11

endmodule

// File: rtl/omc_cell_group.sv
module omc_cell_group #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_we_i,
  input  logic [WIDTH-1:0] cpu_data_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] load_i,
  input  logic [WIDTH-1:0] next_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic cpu_hit;
    assign cpu_hit = cpu_we_i && !mask_i[i];

    // CPU write outranks logic load; protect bit hands priority back to logic
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[i] <= 1'b0;
      else if (cpu_hit)   q_o[i] <= cpu_data_i[i];
      else if (load_i[i]) q_o[i] <= next_i[i];
    end

    AST_MASKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_we_i && mask_i[i] && !load_i[i]) |=> $stable(q_o[i])); // R3
    AST_CPU_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_we_i && !mask_i[i]) |=> (q_o[i] == $past(cpu_data_i[i]))); // R5
    AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i[i] && !(cpu_we_i && !mask_i[i])) |=> (q_o[i] == $past(next_i[i]))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cpu_we_i && !load_i[i]) |=> $stable(q_o[i])); // R6
  end

endmodule

// File: rtl/omc_oe_ctrl.sv
module omc_oe_ctrl #(
  parameter int          N       = 16,
  parameter logic [N-1:0] PIN_MAP = '1,
  parameter logic [N-1:0] EQN_MAP = '1
) (
  input  logic [N-1:0] pt_i,
  input  logic [N-1:0] dir_i,
  output logic [N-1:0] oe_o
);

  for (genvar i = 0; i < N; i++) begin : g_oe
    if (!PIN_MAP[i]) begin : g_node
      assign oe_o[i] = 1'b0;
    end else if (!EQN_MAP[i]) begin : g_always
      assign oe_o[i] = 1'b1;
    end else begin : g_eqn
      assign oe_o[i] = pt_i[i] | dir_i[i];
    end
  end

endmodule

// File: rtl/omc_bank.sv
module omc_bank
  import omc_pkg::*;
#(
  parameter int GROUPS  = 2,
  parameter int WIDTH   = 8,
  localparam int N      = GROUPS * WIDTH,
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int ADDR_W = 2 + GRP_W,
  parameter logic [N-1:0] PIN_MAP = {1'b0, {(N-1){1'b1}}},
  parameter logic [N-1:0] EQN_MAP = {{(N-1){1'b1}}, 1'b0}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [WIDTH-1:0]  cpu_wdata_i,
  output logic [WIDTH-1:0]  cpu_rdata_o,
  input  logic [N-1:0]      mc_load_i,
  input  logic [N-1:0]      mc_next_i,
  input  logic [N-1:0]      pt_oe_i,
  output logic [N-1:0]      mc_q_o,
  output logic [N-1:0]      mc_fb_o,
  output logic [N-1:0]      pin_oe_o
);

  reg_kind_e        kind;
  logic [GRP_W-1:0] grp;
  logic [N-1:0]     mask, dir;
  logic [GROUPS-1:0] cell_we;

  assign kind = reg_kind_e'(cpu_addr_i[ADDR_W-1 -: 2]);
  assign grp  = cpu_addr_i[GRP_W-1:0];

  omc_ctrl_regs #(.GROUPS(GROUPS), .WIDTH(WIDTH), .GRP_W(GRP_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (cpu_we_i),
    .kind_i    (kind),
    .grp_i     (grp),
    .wdata_i   (cpu_wdata_i),
    .mask_o    (mask),
    .dir_o     (dir),
    .cell_we_o (cell_we)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    omc_cell_group #(.WIDTH(WIDTH)) u_cells (
      .clk_i, .rst_ni,
      .cpu_we_i   (cell_we[g]),
      .cpu_data_i (cpu_wdata_i),
      .mask_i     (mask[g*WIDTH +: WIDTH]),
      .load_i     (mc_load_i[g*WIDTH +: WIDTH]),
      .next_i     (mc_next_i[g*WIDTH +: WIDTH]),
      .q_o        (mc_q_o[g*WIDTH +: WIDTH])
    );
  end

  assign mc_fb_o = mc_q_o;

  omc_oe_ctrl #(.N(N), .PIN_MAP(PIN_MAP), .EQN_MAP(EQN_MAP)) u_oe (
    .pt_i  (pt_oe_i),
    .dir_i (dir),
    .oe_o  (pin_oe_o)
  );

  always_comb begin
    cpu_rdata_o = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (grp == GRP_W'(g)) begin
        unique case (kind)
          KIND_CELL: cpu_rdata_o = mc_q_o[g*WIDTH +: WIDTH];
          KIND_MASK: cpu_rdata_o = mask[g*WIDTH +: WIDTH];
          KIND_DIR:  cpu_rdata_o = dir[g*WIDTH +: WIDTH];
          default:   cpu_rdata_o = '0;
        endcase
      end
    end
  end

  AST_RSVD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == KIND_RSVD) |-> (cpu_rdata_o == '0)); // R11
  AST_NODE_NEVER_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_oe_o & ~PIN_MAP) == '0)); // R9

endmodule

// File: tb/omc_bank_test.sv
module omc_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] load = '0, nxt = '0, pt = '0;
  logic [15:0] q, fb, oe;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  omc_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_we_i(we), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .mc_load_i(load),
    .mc_next_i(nxt), .pt_oe_i(pt), .mc_q_o(q), .mc_fb_o(fb), .pin_oe_o(oe)
  );

  // address = {kind, group}
  localparam logic [1:0] K_CELL = 2'b00, K_MASK = 2'b01, K_DIR = 2'b10, K_RSVD = 2'b11;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic g, input logic [7:0] d);
    @(negedge clk);
    we = 1; addr = {k, g}; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [1:0] k, input logic g, output logic [7:0] d);
    addr = {k, g};
    #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int k = 0; k < 4; k++)
      for (int g = 0; g < 2; g++) begin
        rd(k[1:0], g[0], d);
        chk("R1 readback", d, 8'h00);
      end
    chk("R1 q", q, 16'h0000);
    chk("R9 oe at reset", oe, 16'h0001);
  endtask

  task automatic t_cpu_write;
    wr(K_CELL, 0, 8'hA5);
    chk("R2 group0 written", q[7:0], 8'hA5);
    chk("R7 group1 untouched", q[15:8], 8'h00);
    chk("R10 feedback", fb, q);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wr(K_MASK, 0, 8'h0F);
    rd(K_MASK, 0, d);
    chk("R11 mask readback", d, 8'h0F);
    rd(K_MASK, 1, d);
    chk("R7 other mask", d, 8'h00);
    wr(K_CELL, 0, 8'hFF);
    chk("R4 upper writable low kept", q[7:0], 8'hF5);
    wr(K_MASK, 1, 8'hFF);
    wr(K_CELL, 1, 8'h3C);
    chk("R3 fully masked group holds", q[15:8], 8'h00);
    wr(K_MASK, 1, 8'h00);
  endtask

  task automatic t_collision;
    @(negedge clk);
    we = 1; addr = {K_CELL, 1'b0}; wdata = 8'h00;
    load = 16'h00FF; nxt = 16'h00FF;
    @(negedge clk);
    we = 0; load = '0; nxt = '0;
    chk("R5 cpu wins unmasked, load wins masked", q[7:0], 8'h0F);
  endtask

  task automatic t_load;
    @(negedge clk);
    load = 16'h0F00; nxt = 16'hFFFF;
    @(negedge clk);
    load = '0;
    chk("R6 load group1", q[15:8], 8'h0F);
    chk("R6 unloaded group0 holds", q[7:0], 8'h0F);
    @(negedge clk);
    @(negedge clk);
    nxt = '0;
    chk("R6 hold without load", q, 16'h0F0F);
  endtask

  task automatic t_oe;
    wr(K_DIR, 0, 8'h02);
    wr(K_DIR, 1, 8'h80);
    pt = '0; #1;
    chk("R8 dir drives oe, R9 node cell 15 off", oe, 16'h0003);
    pt = 16'h8004; #1;
    chk("R8 product term ORed", oe, 16'h0007);
    pt = '0;
    wr(K_CELL, 1, 8'h80);
    chk("R10 internal node feedback", {31'b0, fb[15]}, 32'h1);
    chk("R9 node oe stays 0", {31'b0, oe[15]}, 32'h0);
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    wr(K_RSVD, 0, 8'hFF);
    rd(K_MASK, 0, d);
    chk("R11 mask unchanged by reserved", d, 8'h0F);
    rd(K_DIR, 0, d);
    chk("R11 dir unchanged by reserved", d, 8'h02);
    rd(K_RSVD, 0, d);
    chk("R11 reserved reads zero", d, 8'h00);
    rd(K_CELL, 0, d);
    chk("R11 cells unchanged", d, 8'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cpu_write();
    t_mask();
    t_collision();
    t_load();
    t_oe();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule